// File: doc/BRIEF.md
# Serial Bus Sampling and Frame Sync Unit

This unit sits at the serial edge of a time-division multiplexed switch. It recovers one data bit per bit cell from a backplane data line and one from a local-bus data line. It detects the active-low frame sync arriving from the backplane and generates the unit's own active-low frame sync. It also gates the output enables of the two serial data drivers so that a driver leaving tri-state can be held off briefly, which prevents contention with the previous owner of the line. One reference clock `clk` runs at four times the bit rate. A free-running phase counter splits each bit cell into phases 0 to 3. The bus clock is taken as high in phases 0 and 1, with its rising edge at phase 0. The double-rate clock has a period of two ticks, and its rising edge inside the bus-clock high half falls at phase 1.

Eight control bits arrive as one configuration byte `cfg_i`. The bit positions are fixed because a neighbouring register decodes them: bit 0 selects the backplane sample point, bit 1 the local sample point, bit 2 the backplane output delay, bit 3 the local output delay, bit 4 the frame sync sample point, bit 5 the generated frame sync width, bit 6 the double-rate clock output disable, and bit 7 the alternate-signal output enable. The register that owns the byte clears it at reset. The unit itself holds no copy of it.

Top module: `sbs_unit`

## Requirements
- R1: After `rst` is released, the first reference cycle is phase 0, and the phase advances by one every cycle, modulo 4. When cfg bit 0 is 0, `bp_din` is captured in the phase 2 cycle. In the following cycle `bp_vld` is 1 for exactly one cycle and `bp_bit` shows the captured value. `bp_bit` holds its value between strobes.
- R2: When cfg bit 0 is 1 and `dbl_present` is 1, the backplane capture moves to phase 3 and the strobe follows in the next cycle.
- R3: When cfg bit 0 is 1 but `dbl_present` is 0, the backplane capture stays at phase 2.
- R4: Local-bus capture follows cfg bit 1 in the same way: phase 3 if bit 1 is 1 and either `dbl_present` or `rate_differ` is 1, otherwise phase 2. The result appears on `lc_bit` and `lc_vld`.
- R5: When a lane's delay bit is 1 (cfg bit 2 for lane 0 backplane, bit 3 for lane 1 local), that lane's `oe_out` stays 0 in the first cycle that `oe_req` is 1. It follows `oe_req` from the next cycle on.
- R6: When a lane's delay bit is 0, `oe_out` equals `oe_req` in the same cycle. In either mode, `oe_out` is 0 in any cycle where `oe_req` is 0.
- R7: The frame has FRAME_BITS bit cells, and bit cell 0 starts at the first phase 0 after reset. `fsync_n` is 0 in bit cell 0, for all four phases when cfg bit 5 is 0, and only in phases 0 and 1 when it is 1. It is 1 at all other times.
- R8: `fs_in_n` is sampled at phase 0 when cfg bit 4 is 0 and at phase 1 when it is 1. If the sample is 0, `fs_hit` is 1 for one cycle in the next cycle.
- R9: `dclk_oe` is the inverse of cfg bit 6. `alt_oe` equals cfg bit 7.
- R10: While `rst` is 1, `bp_vld`, `lc_vld` and `fs_hit` are 0, `fsync_n` is 0 (phase 0 of bit cell 0), and `oe_out` of a lane with its delay bit set is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four ticks per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| dbl_present | input | 1 | Double-rate clock is present |
| rate_differ | input | 1 | Local bus runs at a rate different from the backplane |
| cfg_i | input | 8 | Configuration byte |
| bp_din | input | 1 | Backplane serial data in |
| lc_din | input | 1 | Local-bus serial data in |
| fs_in_n | input | 1 | Active-low frame sync from the backplane |
| oe_req | input | 2 | Driver enable requests (0 backplane, 1 local) |
| bp_bit | output | 1 | Last captured backplane bit |
| bp_vld | output | 1 | Backplane capture strobe |
| lc_bit | output | 1 | Last captured local bit |
| lc_vld | output | 1 | Local capture strobe |
| fs_hit | output | 1 | Frame sync seen low at its sample point |
| fsync_n | output | 1 | Generated active-low frame sync |
| oe_out | output | 2 | Driver enables after turn-on delay |
| dclk_oe | output | 1 | Enable for the double-rate clock outputs |
| alt_oe | output | 1 | Enable for the alternate signal outputs |

## Verification
The assertions check every cycle that a disabled request never leaves a driver on, and that a delayed lane is held off on the cycle its request rises. They also check that each strobe carries the data value present one cycle earlier, that a strobe never lasts two cycles, that `fs_hit` only follows a low frame sync sample, and that the generated frame sync never shows a one-tick high gap while the configuration is steady. Which phase each capture lands on, the fallback to the 50% point when its clock condition fails, and the position and width of `fsync_n` within the frame are shown only by the bench's scenarios. The bench tracks phase and bit-cell counts independently to do this.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Configuration byte, MSB first; bit positions are fixed by the decoder.
    typedef struct packed {
        logic alt_en;     // 7
        logic dclk_off;   // 6
        logic fs_short;   // 5
        logic fs_late;    // 4
        logic lc_delay;   // 3
        logic bp_delay;   // 2
        logic lc_late;    // 1
        logic bp_late;    // 0
    } sbs_cfg_t;

    typedef logic [1:0] phase_t;

    localparam phase_t PH_BUS_RISE = 2'd0;
    localparam phase_t PH_DBL_RISE = 2'd1;
    localparam phase_t PH_HALF     = 2'd2;
    localparam phase_t PH_3Q       = 2'd3;
    localparam phase_t PH_LAST     = 2'd3;

    typedef struct packed {
        logic bit_val;
        logic strobe;
    } sample_t;

    function automatic phase_t pick_phase(input logic want_late, input logic late_ok);
        return (want_late && late_ok) ? PH_3Q : PH_HALF;
    endfunction

    function automatic phase_t fs_phase(input logic late);
        return late ? PH_DBL_RISE : PH_BUS_RISE;
    endfunction

endpackage

// File: rtl/sbs_timebase.sv
module sbs_timebase
    import sbs_pkg::*;
#(
    parameter int FRAME_BITS = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fs_short,
    output phase_t phase,
    output logic   fsync_n
);
    localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

    logic [CW-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_BUS_RISE;
            bit_q <= '0;
        end else begin
            phase <= phase + 2'd1;
            if (phase == PH_LAST)
                bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
        end
    end

    always_comb begin
        fsync_n = !((bit_q == '0) && (!fs_short || (phase < PH_HALF)));
    end

endmodule

// File: rtl/sbs_sampler.sv
module sbs_sampler
    import sbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_t  phase,
    input  logic    want_late,
    input  logic    late_ok,
    input  logic    din,
    output sample_t smp
);
    phase_t tgt;
    assign tgt = pick_phase(want_late, late_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else begin
            smp.strobe <= (phase == tgt);
            if (phase == tgt)
                smp.bit_val <= din;
        end
    end

endmodule

// File: rtl/sbs_oe_delay.sv
module sbs_oe_delay #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] req,
    input  logic [LANES-1:0] dly,
    output logic [LANES-1:0] oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst) req_q <= 1'b0;
            else     req_q <= req[g];
        end
        assign oe[g] = req[g] & (~dly[g] | req_q);
    end

endmodule

// File: rtl/sbs_unit.sv
module sbs_unit
    import sbs_pkg::*;
#(
    parameter int FRAME_BITS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dbl_present,
    input  logic       rate_differ,
    input  logic [7:0] cfg_i,
    input  logic       bp_din,
    input  logic       lc_din,
    input  logic       fs_in_n,
    input  logic [1:0] oe_req,
    output logic       bp_bit,
    output logic       bp_vld,
    output logic       lc_bit,
    output logic       lc_vld,
    output logic       fs_hit,
    output logic       fsync_n,
    output logic [1:0] oe_out,
    output logic       dclk_oe,
    output logic       alt_oe
);
    localparam int LANES = 2;

    sbs_cfg_t cfg;
    assign cfg = sbs_cfg_t'(cfg_i);

    phase_t phase;

    sbs_timebase #(.FRAME_BITS(FRAME_BITS)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .fs_short (cfg.fs_short),
        .phase    (phase),
        .fsync_n  (fsync_n)
    );

    logic [LANES-1:0] want_late, late_ok, din;
    sample_t          smp [LANES];

    assign want_late = {cfg.lc_late, cfg.bp_late};
    assign late_ok   = {dbl_present | rate_differ, dbl_present};
    assign din       = {lc_din, bp_din};

    for (genvar g = 0; g < LANES; g++) begin : g_smp
        sbs_sampler u_smp (
            .clk       (clk),
            .rst       (rst),
            .phase     (phase),
            .want_late (want_late[g]),
            .late_ok   (late_ok[g]),
            .din       (din[g]),
            .smp       (smp[g])
        );
    end

    assign bp_bit = smp[0].bit_val;
    assign bp_vld = smp[0].strobe;
    assign lc_bit = smp[1].bit_val;
    assign lc_vld = smp[1].strobe;

    always_ff @(posedge clk) begin
        if (rst) fs_hit <= 1'b0;
        else     fs_hit <= (phase == fs_phase(cfg.fs_late)) && !fs_in_n;
    end

    sbs_oe_delay #(.LANES(LANES)) u_oe (
        .clk (clk),
        .rst (rst),
        .req (oe_req),
        .dly ({cfg.lc_delay, cfg.bp_delay}),
        .oe  (oe_out)
    );

    assign dclk_oe = !cfg.dclk_off;
    assign alt_oe  = cfg.alt_en;

endmodule

// File: rtl/sbs_unit_chk.sv
module sbs_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_i,
    input logic       bp_din,
    input logic       lc_din,
    input logic       fs_in_n,
    input logic [1:0] oe_req,
    input logic       bp_bit,
    input logic       bp_vld,
    input logic       lc_bit,
    input logic       lc_vld,
    input logic       fs_hit,
    input logic       fsync_n,
    input logic [1:0] oe_out
);
    AST_OE_OFF_NOW: assert property (@(posedge clk) disable iff (rst)
        (oe_out & ~oe_req) == 2'b00); // R6
    AST_BP_TURNON_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_i[2] && $rose(oe_req[0])) |-> !oe_out[0]); // R5
    AST_LC_TURNON_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_i[3] && $rose(oe_req[1])) |-> !oe_out[1]); // R5
    AST_BP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        bp_vld |-> (bp_bit == $past(bp_din))); // R1
    AST_LC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        lc_vld |-> (lc_bit == $past(lc_din))); // R4
    AST_BP_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bp_vld |=> !bp_vld); // R1
    AST_FS_HIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fs_hit |-> !$past(fs_in_n)); // R8
    AST_FSYNC_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
        ($rose(fsync_n) && $stable(cfg_i)) |=> (fsync_n || !$stable(cfg_i))); // R7
endmodule

bind sbs_unit sbs_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_i   (cfg_i),
    .bp_din  (bp_din),
    .lc_din  (lc_din),
    .fs_in_n (fs_in_n),
    .oe_req  (oe_req),
    .bp_bit  (bp_bit),
    .bp_vld  (bp_vld),
    .lc_bit  (lc_bit),
    .lc_vld  (lc_vld),
    .fs_hit  (fs_hit),
    .fsync_n (fsync_n),
    .oe_out  (oe_out)
);

// File: tb/tb_sbs_unit.sv
`timescale 1ns/1ps
module tb_sbs_unit;
    localparam int FB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbl_present = 1'b0, rate_differ = 1'b0;
    logic [7:0] cfg_i = 8'h00;
    logic       bp_din = 1'b0, lc_din = 1'b0, fs_in_n = 1'b1;
    logic [1:0] oe_req = 2'b00;
    logic       bp_bit, bp_vld, lc_bit, lc_vld, fs_hit, fsync_n, dclk_oe, alt_oe;
    logic [1:0] oe_out;

    sbs_unit #(.FRAME_BITS(FB)) dut (
        .clk(clk), .rst(rst), .dbl_present(dbl_present), .rate_differ(rate_differ),
        .cfg_i(cfg_i), .bp_din(bp_din), .lc_din(lc_din), .fs_in_n(fs_in_n),
        .oe_req(oe_req), .bp_bit(bp_bit), .bp_vld(bp_vld), .lc_bit(lc_bit),
        .lc_vld(lc_vld), .fs_hit(fs_hit), .fsync_n(fsync_n), .oe_out(oe_out),
        .dclk_oe(dclk_oe), .alt_oe(alt_oe)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    int   ph_m = 0, cell_m = 0;
    logic bpb_m = 0, bpv_m = 0, lcb_m = 0, lcv_m = 0, fsh_m = 0;
    logic [1:0] reqd_m = 2'b00;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int cap_phase(input logic late, input logic ok);
        return (late && ok) ? 3 : 2;
    endfunction

    function automatic string bp_tag(input logic late, input logic dp);
        if (late && dp) return "R2";
        if (late) return "R3";
        return "R1";
    endfunction

    task automatic check_outputs();
        logic [1:0] exp_oe;
        logic       exp_fs;
        exp_fs = !((cell_m == 0) && (!cfg_i[5] || ph_m < 2));
        chk("R7 fsync_n", {7'd0, fsync_n}, {7'd0, exp_fs});
        chk(bp_tag(cfg_i[0], dbl_present), {6'd0, bp_vld, bp_bit}, {6'd0, bpv_m, bpb_m});
        chk("R4 local", {6'd0, lc_vld, lc_bit}, {6'd0, lcv_m, lcb_m});
        chk("R8 fs_hit", {7'd0, fs_hit}, {7'd0, fsh_m});
        chk("R9 clk enables", {6'd0, dclk_oe, alt_oe}, {6'd0, !cfg_i[6], cfg_i[7]});
        for (int i = 0; i < 2; i++) begin
            exp_oe[i] = oe_req[i] && (!cfg_i[2+i] || reqd_m[i]);
            if (cfg_i[2+i] && oe_req[i] && !reqd_m[i])
                chk("R5 turn-on delay", {7'd0, oe_out[i]}, {7'd0, exp_oe[i]});
            else
                chk("R6 oe follow", {7'd0, oe_out[i]}, {7'd0, exp_oe[i]});
        end
    endtask

    task automatic advance_model();
        int sbp, slc, sfs;
        sbp = cap_phase(cfg_i[0], dbl_present);
        slc = cap_phase(cfg_i[1], dbl_present | rate_differ);
        sfs = cfg_i[4] ? 1 : 0;
        bpv_m = (ph_m == sbp);
        if (bpv_m) bpb_m = bp_din;
        lcv_m = (ph_m == slc);
        if (lcv_m) lcb_m = lc_din;
        fsh_m = (ph_m == sfs) && !fs_in_n;
        reqd_m = oe_req;
        if (ph_m == 3) cell_m = (cell_m == FB - 1) ? 0 : cell_m + 1;
        ph_m = (ph_m + 1) % 4;
    endtask

    // one reference cycle: drive at negedge, check, update model for next edge
    task automatic step(input logic [7:0] cfg, input logic dp, input logic rd, input int oe_mode);
        @(negedge clk);
        rst = 1'b0;
        cfg_i = cfg;
        dbl_present = dp;
        rate_differ = rd;
        bp_din = 1'($urandom);
        lc_din = 1'($urandom);
        fs_in_n = 1'($urandom);
        if (oe_mode == 0) oe_req = 2'($urandom);
        else if (($urandom % 5) == 0) oe_req = ~oe_req;
        #1;
        check_outputs();
        advance_model();
    endtask

    task automatic seg(input int n, input logic [7:0] cfg, input logic dp, input logic rd, input int oe_mode);
        for (int k = 0; k < n; k++) step(cfg, dp, rd, oe_mode);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R10: reset state
        cfg_i = 8'h0C;
        oe_req = 2'b11;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            chk("R10 strobes", {5'd0, bp_vld, lc_vld, fs_hit}, 8'd0);
            chk("R10 fsync_n", {7'd0, fsync_n}, 8'd0);
            chk("R10 oe held", {6'd0, oe_out}, 8'd0);
        end
        // directed corners
        seg(200, 8'h00, 1'b0, 1'b0, 1);   // R1 50% points, R7 wide fsync
        seg(120, 8'h01, 1'b0, 1'b0, 1);   // R3 fallback
        seg(120, 8'h01, 1'b1, 1'b0, 1);   // R2 75% point
        seg(120, 8'h02, 1'b0, 1'b0, 1);   // R4 fallback
        seg(120, 8'h02, 1'b0, 1'b1, 1);   // R4 via rate difference
        seg(120, 8'h02, 1'b1, 1'b0, 1);   // R4 via double-rate clock
        seg(120, 8'h10, 1'b1, 1'b0, 0);   // R8 late sample
        seg(120, 8'h20, 1'b1, 1'b0, 0);   // R7 short fsync
        seg(200, 8'h0C, 1'b0, 1'b0, 1);   // R5 delayed turn-on
        seg(40,  8'h40, 1'b0, 1'b0, 0);   // R9
        seg(40,  8'h80, 1'b0, 1'b0, 0);   // R9
        // random mix
        for (int s = 0; s < 60; s++)
            seg(48, 8'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 2));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule